// File: doc/BRIEF.md
# Polarity-Selectable Phase Frequency Detector

This block sits between the two dividers of a frequency synthesizer loop and the charge pump. It receives a single-cycle pulse each time the reference divider wraps (`refPulse`) and each time the main feedback divider wraps (`divPulse`). From these it derives which signal is ahead, and drives two pump-control lines plus a combined three-level correction line that the charge pump can leave floating in lock.

A polarity input (`polHigh`) adapts the block to a VCO whose frequency rises with tuning voltage (`polHigh` = 1) or falls with it (`polHigh` = 0). The same input also chooses which of the two divider pulse trains is copied to a test output. This lets a bench or production test confirm the divider programming without probing the loop. The combined line is modelled as a level plus an enable rather than a true tri-state pin. The floating-input default of the polarity pin is a board tie-off and sits outside this block.

Top module: `pfd_polarity_top`

## Requirements
- R1: During and right after reset (`rstN` low), no edge is pending, `phiR` = 0, `phiPn` = 1, `doEn` = 0 and `testOut` = 0.
- R2: A pulse on `refPulse` or `divPulse` sampled at a rising clock edge is pending from that edge on. A further pulse on an input whose edge is already pending changes nothing at the ports.
- R3: With `polHigh` = 1 and only the feedback edge pending (feedback ahead), `phiR` = 1, `phiPn` = 1, `doEn` = 1 and `doLvl` = 0 (lower the VCO).
- R4: With `polHigh` = 1 and only the reference edge pending (feedback behind), `phiR` = 0, `phiPn` = 0, `doEn` = 1 and `doLvl` = 1 (raise the VCO).
- R5: With `polHigh` = 0 the two cases swap: feedback-only gives the R4 output pattern and reference-only gives the R3 output pattern. The decode follows `polHigh` in the same cycle.
- R6: When both edges are pending, the outputs are idle (`phiR` = 0, `phiPn` = 1, `doEn` = 0) for exactly one cycle and both clear at the next edge. A pulse sampled at that clearing edge stays pending.
- R7: Pulses on both inputs at the same edge (equal phase) produce no correction cycle: the outputs stay idle.
- R8: `testOut` is a one-cycle-delayed copy of `refPulse` when `polHigh` = 1 and of `divPulse` when `polHigh` = 0 (the value of `polHigh` at the sampling edge).
- R9: The correction output stays active for exactly the number of cycles between the leading and trailing edges. With the two trains of period P offset by P/2, it is active for half of every period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refPulse | input | 1 | One-cycle pulse from the reference divider |
| divPulse | input | 1 | One-cycle pulse from the feedback divider |
| polHigh | input | 1 | VCO slope select; also selects the test output source |
| phiR | output | 1 | Active-high pump-down request |
| phiPn | output | 1 | Active-low pump-up request |
| doLvl | output | 1 | Level of the combined correction line |
| doEn | output | 1 | Drive enable of the combined correction line (0 = high impedance) |
| testOut | output | 1 | Registered copy of the selected divider pulse |

## Verification
An edge flag that sticks or clears wrongly shows on the very next sample as an enable on the combined line that is either missing or never drops. A stuck flag also stretches the active time in the half-period run, so the total active count over three periods is wrong. A swapped polarity decode appears in the same cycle as a wrong `phiR`/`phiPn` pair, and a wrong test-output source appears one cycle after the pulse. Each cycle's ports are compared against a model of the pending edges, so any divergence is reported in the cycle where it starts.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef struct packed {
    logic setRef;
    logic setDiv;
    logic clearBoth;
  } pfdStrobe_t;
endpackage

// File: rtl/pfd_ctrl.sv
module pfd_ctrl
  import pfd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       refPulse,
  input  logic       divPulse,
  input  logic       refFlag,
  input  logic       divFlag,
  output pfdStrobe_t strb
);
  always_comb begin
    strb.setRef    = refPulse;
    strb.setDiv    = divPulse;
    strb.clearBoth = refFlag & divFlag;
  end

  // R6: a clear request never appears unless both edges are pending
  a_r6_clear_needs_both: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearBoth |-> (refFlag && divFlag));
endmodule

// File: rtl/pfd_dp.sv
module pfd_dp
  import pfd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  pfdStrobe_t strb,
  input  logic       polHigh,
  input  logic       refPulse,
  input  logic       divPulse,
  output logic       refFlag,
  output logic       divFlag,
  output logic       phiR,
  output logic       phiPn,
  output logic       doLvl,
  output logic       doEn,
  output logic       testOut
);
  logic refOnly, divOnly, lowerReq, raiseReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refFlag <= 1'b0;
      divFlag <= 1'b0;
      testOut <= 1'b0;
    end else begin
      refFlag <= strb.clearBoth ? strb.setRef : (refFlag | strb.setRef);
      divFlag <= strb.clearBoth ? strb.setDiv : (divFlag | strb.setDiv);
      testOut <= polHigh ? refPulse : divPulse;
    end
  end

  always_comb begin
    refOnly  = refFlag & ~divFlag;
    divOnly  = divFlag & ~refFlag;
    lowerReq = polHigh ? divOnly : refOnly;
    raiseReq = polHigh ? refOnly : divOnly;
    phiR     = lowerReq;
    phiPn    = ~raiseReq;
    doEn     = refOnly | divOnly;
    doLvl    = raiseReq;
  end

  // R2: a sampled pulse is pending after the edge
  a_r2_ref_capture: assert property (@(posedge clk) disable iff (!rstN)
    strb.setRef |=> refFlag);
  a_r2_div_capture: assert property (@(posedge clk) disable iff (!rstN)
    strb.setDiv |=> divFlag);
  // R6: both pending with no new pulse clears both
  a_r6_clear_both: assert property (@(posedge clk) disable iff (!rstN)
    (refFlag && divFlag && !strb.setRef && !strb.setDiv) |=> (!refFlag && !divFlag));
  // R6/R7: idle pump pattern whenever the combined line floats
  a_r6_idle_float: assert property (@(posedge clk) disable iff (!rstN)
    !doEn |-> (!phiR && phiPn));
  // R3: driving low means pump-down active and pump-up idle
  a_r3_low_is_down: assert property (@(posedge clk) disable iff (!rstN)
    (doEn && !doLvl) |-> (phiR && phiPn));
  // R4: driving high means pump-up active and pump-down idle
  a_r4_high_is_up: assert property (@(posedge clk) disable iff (!rstN)
    (doEn && doLvl) |-> (!phiR && !phiPn));
endmodule

// File: rtl/pfd_polarity_top.sv
module pfd_polarity_top
  import pfd_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic refPulse,
  input  logic divPulse,
  input  logic polHigh,
  output logic phiR,
  output logic phiPn,
  output logic doLvl,
  output logic doEn,
  output logic testOut
);
  pfdStrobe_t strb;
  logic refFlag, divFlag;

  pfd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .refPulse(refPulse), .divPulse(divPulse),
    .refFlag(refFlag), .divFlag(divFlag), .strb(strb)
  );

  pfd_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .polHigh(polHigh),
    .refPulse(refPulse), .divPulse(divPulse),
    .refFlag(refFlag), .divFlag(divFlag),
    .phiR(phiR), .phiPn(phiPn), .doLvl(doLvl), .doEn(doEn), .testOut(testOut)
  );
endmodule

// File: tb/pfd_polarity_top_tb.sv
module pfd_polarity_top_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refPulse = 1'b0, divPulse = 1'b0, polHigh = 1'b1;
  logic phiR, phiPn, doLvl, doEn, testOut;

  int checks = 0, fails = 0, cyc = 0, r9Active = 0;
  logic mRef = 1'b0, mDiv = 1'b0;
  logic done = 1'b0;

  typedef struct {
    int    due;
    logic  eRef;
    logic  eDiv;
    logic  eTst;
    string tag;
  } item_t;
  item_t q[$];

  pfd_polarity_top u_dut (
    .clk(clk), .rstN(rstN), .refPulse(refPulse), .divPulse(divPulse),
    .polHigh(polHigh), .phiR(phiR), .phiPn(phiPn), .doLvl(doLvl),
    .doEn(doEn), .testOut(testOut)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, pushes the expected pending state
  task automatic step(input logic r, input logic d, input logic fc, input string tag);
    logic clr, nRef, nDiv;
    item_t it;
    @(posedge clk); #1;
    refPulse = r; divPulse = d; polHigh = fc;
    clr  = mRef & mDiv;
    nRef = clr ? r : (mRef | r);
    nDiv = clr ? d : (mDiv | d);
    mRef = nRef; mDiv = nDiv;
    it.due = cyc + 1; it.eRef = nRef; it.eDiv = nDiv;
    it.eTst = fc ? r : d; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input int n, input logic fc, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, fc, tag);
  endtask

  // monitor: compare ports with the popped expectation
  always @(posedge clk) begin
    cyc++;
    #4;
    while (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      logic ro, dOnly, dec, inc, en;
      it = q.pop_front();
      ro = it.eRef & ~it.eDiv;
      dOnly = it.eDiv & ~it.eRef;
      dec = polHigh ? dOnly : ro;
      inc = polHigh ? ro : dOnly;
      en = ro | dOnly;
      check(phiR == dec && phiPn == ~inc, it.tag, "phiR,phiPn",
            {phiR, phiPn}, {dec, ~inc});
      check(doEn == en && (!en || doLvl == inc), it.tag, "doEn,doLvl",
            {doEn, doLvl}, {en, inc});
      check(testOut == it.eTst, it.tag, "testOut", testOut, it.eTst);
      if (it.tag == "R9" && doEn) r9Active++;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #4;
    check(!phiR && phiPn && !doEn && !testOut, "R1", "reset outputs",
          {phiR, phiPn, doEn, testOut}, 4'b0100);
    @(posedge clk); #1; rstN = 1'b1;
    idle(2, 1'b1, "R1");
    // R3: feedback ahead, positive slope
    step(1'b0, 1'b1, 1'b1, "R3"); idle(3, 1'b1, "R3");
    step(1'b1, 1'b0, 1'b1, "R6"); idle(2, 1'b1, "R6");
    // R4: reference ahead, repeated reference pulse ignored (R2)
    step(1'b1, 1'b0, 1'b1, "R4"); idle(2, 1'b1, "R4");
    step(1'b1, 1'b0, 1'b1, "R2"); idle(1, 1'b1, "R2");
    step(1'b0, 1'b1, 1'b1, "R6"); idle(2, 1'b1, "R6");
    // R5: negative slope swaps directions
    step(1'b0, 1'b1, 1'b0, "R5"); idle(3, 1'b0, "R5");
    step(1'b1, 1'b0, 1'b0, "R5"); idle(1, 1'b0, "R5");
    step(1'b1, 1'b0, 1'b0, "R5"); idle(2, 1'b0, "R5");
    step(1'b0, 1'b1, 1'b0, "R5"); idle(2, 1'b0, "R5");
    // R5: polarity flipped while an edge is pending
    step(1'b1, 1'b0, 1'b1, "R5"); idle(1, 1'b1, "R5"); idle(1, 1'b0, "R5");
    step(1'b0, 1'b1, 1'b0, "R5"); idle(2, 1'b0, "R5");
    // R7: simultaneous edges
    step(1'b1, 1'b1, 1'b1, "R7"); idle(2, 1'b1, "R7");
    step(1'b1, 1'b1, 1'b0, "R7"); idle(2, 1'b0, "R7");
    // R6: pulse in the clearing cycle stays pending
    step(1'b1, 1'b0, 1'b1, "R6"); step(1'b0, 1'b1, 1'b1, "R6");
    step(1'b1, 1'b0, 1'b1, "R6"); idle(2, 1'b1, "R6");
    step(1'b0, 1'b1, 1'b1, "R6"); idle(2, 1'b1, "R6");
    // R8: test output source follows polarity
    step(1'b1, 1'b0, 1'b0, "R8"); step(1'b0, 1'b1, 1'b0, "R8");
    step(1'b0, 1'b1, 1'b1, "R8"); step(1'b1, 1'b0, 1'b1, "R8");
    idle(3, 1'b1, "R8");
    // R9: 180 degree offset, period 8, three periods
    for (int p = 0; p < 3; p++) begin
      step(1'b1, 1'b0, 1'b1, "R9"); idle(3, 1'b1, "R9");
      step(1'b0, 1'b1, 1'b1, "R9"); idle(3, 1'b1, "R9");
    end
    idle(3, 1'b1, "R1");
    repeat (2) @(posedge clk);
    #6;
    check(r9Active == 12, "R9", "active cycles", r9Active, 12);
    check(q.size() == 0, "R2", "pending expectations", q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule